// File: doc/BRIEF.md
# Level-Sensitive Interrupt Collector with Sorted Source Register

This block gathers a parameterised number of level-sensitive interrupt lines (96 or 128) into one processor interrupt. The lines are organised in groups of thirty-two. Each group has a mask word, two write-one mask update words (one sets mask bits, one clears them) and a read-only pending word. A processor reaches all of these through a small register bus with a one-cycle read latency.

Delivery is one source at a time. While the controller is scanning, it picks the lowest-numbered source that is raised and not masked, latches its number into a sorted-source register and raises `irq_o`. The latched number stays fixed until software writes the acknowledge bit. The controller then goes back to scanning and can take the next source. A soft reset can be started by writing a configuration bit. It returns every stored setting to its default and reports when it is done through a status bit. The same sequence also runs after the hardware reset.

The sequencing is a three-state machine. ST_SRST holds all settings at their defaults for `RST_CYCLES` clocks. ST_SCAN evaluates the sources on every clock. ST_HOLD presents the latched source. The transitions are:
- SRST_DONE: ST_SRST to ST_SCAN, once the counter expires.
- LATCH: ST_SCAN to ST_HOLD, when an unmasked source is raised.
- ACK: ST_HOLD to ST_SCAN, on an acknowledge write.
- SOFT_RESET: ST_SCAN or ST_HOLD to ST_SRST, on a soft reset write.

Top module: `lvl_irq_hub`

## Requirements
- R1: After the hardware reset, and after a soft reset, every source is masked (mask words read 0xFFFFFFFF). The sorted register reads 0x80, the autoidle bit, the level words and the three storage words read 0, and `irq_o` is low.
- R2: Address 0x000 reads a revision word with `REV_MAJOR` in bits 7:4, `REV_MINOR` in bits 3:0 and zeros above.
- R3: Writing a word with bit 1 set to 0x010 starts a soft reset. Bit 0 of 0x014 reads 0 for the `RST_CYCLES` clocks the sequence lasts (this also applies after the hardware reset) and 1 afterwards. Bus writes made during the sequence are ignored, and bit 1 of 0x010 always reads 0.
- R4: Bit 0 of 0x010 is the autoidle bit. It is written directly and reads back the last value written.
- R5: Group g (source 32g+b is bit b) has its mask word at 0x084+0x20·g, written directly. Its mask-clear word is at 0x088+0x20·g and its mask-set word at 0x08C+0x20·g. A 1 in a mask-clear write clears that mask bit, a 1 in a mask-set write sets it, and 0 bits leave the mask unchanged. Both update words read 0.
- R6: The pending word at 0x098+0x20·g reads the raw source lines AND NOT the group's mask.
- R7: On each clock in ST_SCAN, address 0x040 is loaded with the lowest-numbered raised, unmasked source in bits 6:0 with bit 7 clear, or with 0x80 if there is none. While in ST_HOLD the value stays frozen, even if the source drops or is masked.
- R8: `irq_o` is high exactly while in ST_HOLD. Writing a word with bit 0 set to 0x048 drops `irq_o` on the next clock. The next scan happens on the clock after that. A write to 0x048 with bit 0 clear has no effect.
- R9: The level word for source n sits at 0x100+4·n and reads back the last 32-bit value written. Word addresses at or beyond `NUM_SRC` read 0.
- R10: The words at 0x04C, 0x050 and 0x068 are 32-bit storage only. They read back what was written and do not affect delivery.
- R11: A read request returns its data on `bus_rdata_o` with `bus_rvalid_o` high exactly one clock later. Unmapped and unaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_en_i | input | 1 | Bus request strobe |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with `bus_rvalid_o` |
| bus_rvalid_o | output | 1 | Read data valid, one clock after the request |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A mask bit that is set or cleared wrongly shows up at once in the group's pending word. One clock later it also shows up on `irq_o` and in the sorted register, because the next scan either takes a source it should have skipped or misses one. A state machine stuck in ST_HOLD, or one that leaves it too early, shows up at the next acknowledge: `irq_o` either fails to drop or does not come back within two clocks while a source is still raised. A soft reset counter of the wrong length makes the status bit change at a different clock from the bench's model, and that difference is seen at the first status poll.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;
    localparam int unsigned GRP_W  = 32;
    localparam int unsigned IDX_W  = 7;

    localparam logic [BUS_AW-1:0] OFS_REV      = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_SYSCFG   = 12'h010;
    localparam logic [BUS_AW-1:0] OFS_SYSSTAT  = 12'h014;
    localparam logic [BUS_AW-1:0] OFS_SORTED   = 12'h040;
    localparam logic [BUS_AW-1:0] OFS_CTRL     = 12'h048;
    localparam logic [BUS_AW-1:0] OFS_PROT     = 12'h04C;
    localparam logic [BUS_AW-1:0] OFS_IDLE     = 12'h050;
    localparam logic [BUS_AW-1:0] OFS_THRESH   = 12'h068;
    localparam logic [BUS_AW-1:0] OFS_GRP_BASE = 12'h080;
    localparam logic [BUS_AW-1:0] OFS_LVL_BASE = 12'h100;

    // offsets inside one 0x20-byte group window
    localparam logic [4:0] SUB_MASK = 5'h04;
    localparam logic [4:0] SUB_MCLR = 5'h08;
    localparam logic [4:0] SUB_MSET = 5'h0C;
    localparam logic [4:0] SUB_PEND = 5'h18;

    localparam logic [7:0] SORTED_NONE = 8'h80;

    typedef enum logic [1:0] {
        ST_SRST = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } hub_state_e;

    typedef enum logic [1:0] {
        MOP_NONE  = 2'd0,
        MOP_WRITE = 2'd1,
        MOP_SET   = 2'd2,
        MOP_CLR   = 2'd3
    } mask_op_e;

endpackage

// File: rtl/lvl_irq_mask_bank.sv
module lvl_irq_mask_bank
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 96,
    parameter int unsigned NUM_GRP = NUM_SRC / GRP_W,
    parameter int unsigned GSEL_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  mask_op_e           op_i,
    input  logic [GSEL_W-1:0]  grp_i,
    input  logic [BUS_DW-1:0]  wdata_i,
    output logic [NUM_SRC-1:0] mask_o
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [GRP_W-1:0] word_q;
        logic             hit;

        assign hit = (grp_i == GSEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (clear_i) begin
                word_q <= '1;
            end else if (hit) begin
                unique case (op_i)
                    MOP_WRITE: word_q <= wdata_i;
                    MOP_SET:   word_q <= word_q | wdata_i;
                    MOP_CLR:   word_q <= word_q & ~wdata_i;
                    default:   word_q <= word_q;
                endcase
            end
        end

        assign mask_o[g*GRP_W +: GRP_W] = word_q;
    end

endmodule

// File: rtl/lvl_irq_pick.sv
module lvl_irq_pick
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 96
) (
    input  logic [NUM_SRC-1:0] vec_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    // walk downwards so the lowest set index is the one left standing
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lvl_irq_level_store.sv
module lvl_irq_level_store
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 96,
    parameter int unsigned LIDX_W  = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              we_i,
    input  logic [LIDX_W-1:0] idx_i,
    input  logic [BUS_DW-1:0] wdata_i,
    output logic [BUS_DW-1:0] rdata_o
);

    logic [BUS_DW-1:0] word_q [NUM_SRC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) word_q[i] <= '0;
        end else if (clear_i) begin
            for (int i = 0; i < NUM_SRC; i++) word_q[i] <= '0;
        end else if (we_i) begin
            word_q[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = word_q[idx_i];

endmodule

// File: rtl/lvl_irq_hub.sv
module lvl_irq_hub
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 96,
    parameter logic [3:0]  REV_MAJOR  = 4'd2,
    parameter logic [3:0]  REV_MINOR  = 4'd1,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_en_i,
    input  logic               bus_wr_i,
    input  logic [BUS_AW-1:0]  bus_addr_i,
    input  logic [BUS_DW-1:0]  bus_wdata_i,
    output logic [BUS_DW-1:0]  bus_rdata_o,
    output logic               bus_rvalid_o,
    output logic               irq_o
);

    localparam int unsigned NUM_GRP = NUM_SRC / GRP_W;
    localparam int unsigned GSEL_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int unsigned LIDX_W  = $clog2(NUM_SRC);
    localparam int unsigned CNT_W   = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [BUS_AW-1:0] GRP_END  = OFS_GRP_BASE + BUS_AW'(NUM_GRP * 32);
    localparam logic [9:0]        LVL_WBASE = OFS_LVL_BASE[11:2];

    // ---------------- state ----------------
    hub_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [7:0]         sir_q;
    logic               autoidle_q;
    logic [BUS_DW-1:0]  prot_q, idle_q, thr_q;
    logic [BUS_DW-1:0]  rdata_q;
    logic               rvalid_q;

    // ---------------- decode ----------------
    logic               wr_go, rd_go;
    logic               in_grp, in_lvl;
    logic [GSEL_W-1:0]  grp_sel;
    logic [4:0]         sub_ofs;
    logic [9:0]         lvl_word;
    logic [LIDX_W-1:0]  lvl_idx;
    logic               srst_req, ack_req, clear_cfg;
    mask_op_e           mask_op;

    assign wr_go    = bus_en_i && bus_wr_i && (state_q != ST_SRST);
    assign rd_go    = bus_en_i && !bus_wr_i;
    assign in_grp   = (bus_addr_i >= OFS_GRP_BASE) && (bus_addr_i < GRP_END);
    assign grp_sel  = bus_addr_i[5 +: GSEL_W];
    assign sub_ofs  = bus_addr_i[4:0];
    assign lvl_word = bus_addr_i[11:2] - LVL_WBASE;
    assign in_lvl   = (bus_addr_i[11:2] >= LVL_WBASE) && (lvl_word < 10'(NUM_SRC))
                      && (bus_addr_i[1:0] == 2'b00);
    assign lvl_idx  = lvl_word[LIDX_W-1:0];

    assign srst_req  = wr_go && (bus_addr_i == OFS_SYSCFG) && bus_wdata_i[1];
    assign ack_req   = wr_go && (bus_addr_i == OFS_CTRL) && bus_wdata_i[0];
    assign clear_cfg = (state_q == ST_SRST) || srst_req;

    always_comb begin
        mask_op = MOP_NONE;
        if (wr_go && in_grp) begin
            unique case (sub_ofs)
                SUB_MASK: mask_op = MOP_WRITE;
                SUB_MSET: mask_op = MOP_SET;
                SUB_MCLR: mask_op = MOP_CLR;
                default:  mask_op = MOP_NONE;
            endcase
        end
    end

    // ---------------- datapath pieces ----------------
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] pend_w;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic [BUS_DW-1:0]  lvl_rdata;

    lvl_irq_mask_bank #(
        .NUM_SRC (NUM_SRC),
        .NUM_GRP (NUM_GRP),
        .GSEL_W  (GSEL_W)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_cfg),
        .op_i    (mask_op),
        .grp_i   (grp_sel),
        .wdata_i (bus_wdata_i),
        .mask_o  (mask_w)
    );

    assign pend_w = src_i & ~mask_w;

    lvl_irq_pick #(
        .NUM_SRC (NUM_SRC)
    ) u_pick (
        .vec_i   (pend_w),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    lvl_irq_level_store #(
        .NUM_SRC (NUM_SRC),
        .LIDX_W  (LIDX_W)
    ) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_cfg),
        .we_i    (wr_go && in_lvl),
        .idx_i   (lvl_idx),
        .wdata_i (bus_wdata_i),
        .rdata_o (lvl_rdata)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SRST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_SRST: begin
                if (cnt_q == CNT_W'(RST_CYCLES - 1)) begin
                    state_d = ST_SCAN;              // SRST_DONE
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SCAN: begin
                if (srst_req) begin
                    state_d = ST_SRST;              // SOFT_RESET
                end else if (pick_found) begin
                    state_d = ST_HOLD;              // LATCH
                end
            end
            ST_HOLD: begin
                if (srst_req) begin
                    state_d = ST_SRST;              // SOFT_RESET
                end else if (ack_req) begin
                    state_d = ST_SCAN;              // ACK
                end
            end
            default: state_d = ST_SRST;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (state_q)
            ST_HOLD: irq_o = 1'b1;
            default: irq_o = 1'b0;
        endcase
    end

    // sorted source register: reloaded only while scanning
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sir_q <= SORTED_NONE;
        end else if (clear_cfg) begin
            sir_q <= SORTED_NONE;
        end else if (state_q == ST_SCAN) begin
            sir_q <= pick_found ? {1'b0, pick_idx} : SORTED_NONE;
        end
    end

    // ---------------- plain configuration storage ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            autoidle_q <= 1'b0;
            prot_q     <= '0;
            idle_q     <= '0;
            thr_q      <= '0;
        end else if (clear_cfg) begin
            autoidle_q <= 1'b0;
            prot_q     <= '0;
            idle_q     <= '0;
            thr_q      <= '0;
        end else if (wr_go) begin
            if (bus_addr_i == OFS_SYSCFG) autoidle_q <= bus_wdata_i[0];
            if (bus_addr_i == OFS_PROT)   prot_q     <= bus_wdata_i;
            if (bus_addr_i == OFS_IDLE)   idle_q     <= bus_wdata_i;
            if (bus_addr_i == OFS_THRESH) thr_q      <= bus_wdata_i;
        end
    end

    // ---------------- read path ----------------
    logic [BUS_DW-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (bus_addr_i == OFS_REV) begin
            rd_mux = {24'h0, REV_MAJOR, REV_MINOR};
        end else if (bus_addr_i == OFS_SYSCFG) begin
            rd_mux = {31'h0, autoidle_q};
        end else if (bus_addr_i == OFS_SYSSTAT) begin
            rd_mux = {31'h0, (state_q != ST_SRST)};
        end else if (bus_addr_i == OFS_SORTED) begin
            rd_mux = {24'h0, sir_q};
        end else if (bus_addr_i == OFS_PROT) begin
            rd_mux = prot_q;
        end else if (bus_addr_i == OFS_IDLE) begin
            rd_mux = idle_q;
        end else if (bus_addr_i == OFS_THRESH) begin
            rd_mux = thr_q;
        end else if (in_grp) begin
            if (sub_ofs == SUB_MASK) rd_mux = mask_w[{grp_sel, 5'b0} +: GRP_W];
            if (sub_ofs == SUB_PEND) rd_mux = pend_w[{grp_sel, 5'b0} +: GRP_W];
        end else if (in_lvl) begin
            rd_mux = lvl_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_go;
            if (rd_go) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = rvalid_q;

endmodule

// File: rtl/lvl_irq_hub_chk.sv
module lvl_irq_hub_chk
    import lvl_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 96
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en_i,
    input logic               bus_wr_i,
    input logic [BUS_AW-1:0]  bus_addr_i,
    input logic [BUS_DW-1:0]  bus_wdata_i,
    input logic               bus_rvalid_o,
    input logic               irq_o,
    input hub_state_e         state_q,
    input logic [7:0]         sir_q,
    input logic [NUM_SRC-1:0] mask_w,
    input logic [NUM_SRC-1:0] pend_w
);

    localparam logic [NUM_SRC-1:0] LSB_ONE = NUM_SRC'(1);

    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && bus_en_i && bus_wr_i && bus_addr_i == OFS_CTRL && bus_wdata_i[0])
        |=> !irq_o);

    assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(bus_en_i && bus_wr_i)) |=> (irq_o && $stable(sir_q)));

    assert_latch_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (!sir_q[7] && (|(($past(pend_w) >> sir_q[6:0]) & LSB_ONE))));

    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_i && !bus_wr_i) |=> bus_rvalid_o);

    assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en_i && !bus_wr_i) |=> !bus_rvalid_o);

    assert_srst_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRST) |-> (!irq_o && (&mask_w)));

    assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SRST && bus_en_i && bus_wr_i && bus_addr_i == 12'h08C)
        |=> ((mask_w[31:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

endmodule

bind lvl_irq_hub lvl_irq_hub_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en_i     (bus_en_i),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rvalid_o (bus_rvalid_o),
    .irq_o        (irq_o),
    .state_q      (state_q),
    .sir_q        (sir_q),
    .mask_w       (mask_w),
    .pend_w       (pend_w)
);

// File: tb/sim_lvl_irq_hub.sv
module sim_lvl_irq_hub;

    localparam int NS   = 96;
    localparam int RSTC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          en = 1'b0;
    logic          wr = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lvl_irq_hub #(
        .NUM_SRC    (NS),
        .REV_MAJOR  (4'd2),
        .REV_MINOR  (4'd1),
        .RST_CYCLES (RSTC)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src),
        .bus_en_i     (en),
        .bus_wr_i     (wr),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .irq_o        (irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [NS-1:0] m_mask = '1;
    logic [31:0]   m_lvl [NS];
    bit            m_auto = 1'b0;
    logic [31:0]   m_prot = '0, m_idle = '0, m_thr = '0;
    int            m_left = RSTC;
    bit            m_hold = 1'b0;
    logic [7:0]    m_sir = 8'h80;
    bit            e_rvalid = 1'b0;
    logic [31:0]   e_rdata = '0;

    task automatic m_defaults();
        m_mask = '1;
        for (int i = 0; i < NS; i++) m_lvl[i] = '0;
        m_auto = 1'b0;
        m_prot = '0; m_idle = '0; m_thr = '0;
        m_hold = 1'b0;
        m_sir  = 8'h80;
    endtask

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int g, s, w;
        if (a == 12'h000) return 32'h21;
        if (a == 12'h010) return {31'h0, m_auto};
        if (a == 12'h014) return {31'h0, (m_left == 0)};
        if (a == 12'h040) return {24'h0, m_sir};
        if (a == 12'h04C) return m_prot;
        if (a == 12'h050) return m_idle;
        if (a == 12'h068) return m_thr;
        if (a >= 12'h080 && a < 12'h080 + NS) begin
            g = (int'(a) - 'h80) / 32;
            s = (int'(a) - 'h80) % 32;
            if (s == 4)    return m_mask[g*32 +: 32];
            if (s == 'h18) return src[g*32 +: 32] & ~m_mask[g*32 +: 32];
            return '0;
        end
        if (a >= 12'h100 && a[1:0] == 2'b00) begin
            w = (int'(a) - 'h100) / 4;
            if (w < NS) return m_lvl[w];
        end
        return '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_defaults();
            m_left   = RSTC;
            e_rvalid = 1'b0;
            e_rdata  = '0;
        end else begin
            bit found;
            int low;
            found = 1'b0;
            low   = 0;
            for (int i = 0; i < NS; i++) begin
                if (!found && src[i] && !m_mask[i]) begin
                    found = 1'b1;
                    low   = i;
                end
            end
            e_rvalid = en && !wr;
            if (e_rvalid) e_rdata = m_read(addr);
            if (m_left > 0) begin
                m_left--;
            end else if (en && wr && addr == 12'h010 && wdata[1]) begin
                m_defaults();
                m_left = RSTC;
            end else begin
                if (m_hold) begin
                    if (en && wr && addr == 12'h048 && wdata[0]) m_hold = 1'b0;
                end else if (found) begin
                    m_hold = 1'b1;
                    m_sir  = 8'(low);
                end else begin
                    m_sir = 8'h80;
                end
                if (en && wr) begin
                    if (addr == 12'h010) m_auto = wdata[0];
                    if (addr == 12'h04C) m_prot = wdata;
                    if (addr == 12'h050) m_idle = wdata;
                    if (addr == 12'h068) m_thr  = wdata;
                    if (addr >= 12'h080 && addr < 12'h080 + NS) begin
                        int g, s;
                        g = (int'(addr) - 'h80) / 32;
                        s = (int'(addr) - 'h80) % 32;
                        if (s == 4)   m_mask[g*32 +: 32] = wdata;
                        if (s == 8)   m_mask[g*32 +: 32] = m_mask[g*32 +: 32] & ~wdata;
                        if (s == 'hC) m_mask[g*32 +: 32] = m_mask[g*32 +: 32] | wdata;
                    end
                    if (addr >= 12'h100 && addr[1:0] == 2'b00 && (int'(addr) - 'h100) / 4 < NS)
                        m_lvl[(int'(addr) - 'h100) / 4] = wdata;
                end
            end
        end
    end

    // per-clock comparison against the model (R8 irq line, R11 read port)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq === m_hold, "R8 model irq_o", {31'h0, irq}, {31'h0, m_hold});
            check(rvalid === e_rvalid, "R11 model rvalid", {31'h0, rvalid}, {31'h0, e_rvalid});
            if (e_rvalid) check(rdata === e_rdata, "R11 model rdata", rdata, e_rdata);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        en = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        en = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        en = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        d  = rdata;
        en = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        bus_read(a, v);
        check(v === exp, req, v, exp);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    // ---------------- directed scenario ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(irq === 1'b0, "R1 irq low after reset", {31'h0, irq}, 32'h0);
        expect_rd(12'h014, 32'h0, "R3 status busy after reset");
        idle_cycles(RSTC + 2);
        expect_rd(12'h014, 32'h1, "R3 status done");
        expect_rd(12'h040, 32'h80, "R1 sorted none");
        for (int g = 0; g < NS / 32; g++)
            expect_rd(12'(12'h084 + 32 * g), 32'hFFFF_FFFF, "R1 mask all set");
        expect_rd(12'h000, 32'h21, "R2 revision");

        bus_write(12'h010, 32'h1);
        expect_rd(12'h010, 32'h1, "R4 autoidle set");

        bus_write(12'h088, 32'h0000_00F0);
        expect_rd(12'h084, 32'hFFFF_FF0F, "R5 mask clear");
        bus_write(12'h08C, 32'h0000_0010);
        expect_rd(12'h084, 32'hFFFF_FF1F, "R5 mask set");
        expect_rd(12'h08C, 32'h0, "R5 update word reads 0");
        bus_write(12'h0C4, 32'h7FFF_FFFF);
        expect_rd(12'h0C4, 32'h7FFF_FFFF, "R5 direct mask");

        src[5] = 1'b1; src[6] = 1'b1; src[40] = 1'b1; src[95] = 1'b1;
        expect_rd(12'h098, 32'h0000_0060, "R6 pending group0");
        expect_rd(12'h0B8, 32'h0, "R6 pending group1 masked");
        expect_rd(12'h0D8, 32'h8000_0000, "R6 pending group2");
        check(irq === 1'b1, "R8 irq raised", {31'h0, irq}, 32'h1);
        expect_rd(12'h040, 32'h5, "R7 lowest source");

        bus_write(12'h048, 32'h0);
        check(irq === 1'b1, "R8 ack bit0 clear ignored", {31'h0, irq}, 32'h1);
        expect_rd(12'h040, 32'h5, "R8 sorted kept");

        bus_write(12'h048, 32'h1);
        check(irq === 1'b0, "R8 irq drops after ack", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check(irq === 1'b1, "R8 irq back after scan", {31'h0, irq}, 32'h1);

        src[5] = 1'b0;
        expect_rd(12'h040, 32'h5, "R7 latched after source drop");
        bus_write(12'h048, 32'h1);
        idle_cycles(2);
        expect_rd(12'h040, 32'h6, "R7 next source");

        src[6] = 1'b0;
        bus_write(12'h048, 32'h1);
        idle_cycles(2);
        expect_rd(12'h040, 32'd95, "R7 highest source");

        src[95] = 1'b0;
        bus_write(12'h048, 32'h1);
        idle_cycles(2);
        expect_rd(12'h040, 32'h80, "R7 none pending");
        check(irq === 1'b0, "R8 irq low when none", {31'h0, irq}, 32'h0);

        bus_write(12'h10C, 32'hA5A5_0003);
        bus_write(12'(12'h100 + 4 * 95), 32'h1F);
        expect_rd(12'h10C, 32'hA5A5_0003, "R9 level word 3");
        expect_rd(12'(12'h100 + 4 * 95), 32'h1F, "R9 level word last");
        expect_rd(12'(12'h100 + 4 * 96), 32'h0, "R9 beyond range");

        bus_write(12'h04C, 32'h1);
        bus_write(12'h050, 32'h3);
        bus_write(12'h068, 32'h40);
        expect_rd(12'h04C, 32'h1, "R10 protection word");
        expect_rd(12'h050, 32'h3, "R10 idle word");
        expect_rd(12'h068, 32'h40, "R10 threshold word");
        expect_rd(12'h004, 32'h0, "R11 unmapped");
        expect_rd(12'h011, 32'h0, "R11 unaligned");

        src[5] = 1'b1;
        idle_cycles(2);
        check(irq === 1'b1, "R8 irq before soft reset", {31'h0, irq}, 32'h1);
        bus_write(12'h010, 32'h3);
        check(irq === 1'b0, "R1 irq low in soft reset", {31'h0, irq}, 32'h0);
        expect_rd(12'h014, 32'h0, "R3 status busy in soft reset");
        bus_write(12'h088, 32'hFFFF_FFFF);
        idle_cycles(RSTC + 2);
        expect_rd(12'h014, 32'h1, "R3 status done after soft reset");
        expect_rd(12'h010, 32'h0, "R3 config cleared, bit1 reads 0");
        expect_rd(12'h084, 32'hFFFF_FFFF, "R3 write ignored during reset");
        expect_rd(12'h10C, 32'h0, "R1 level cleared");
        expect_rd(12'h04C, 32'h0, "R1 storage cleared");
        check(irq === 1'b0, "R1 masked after soft reset", {31'h0, irq}, 32'h0);

        idle_cycles(2);
        finish_run();
    end

endmodule